// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block times every edge an I2C master puts on the bus. A bit engine hands it one command at a time: a start condition, one data bit, a stop condition or a repeated start. The generator drives the SCL level. It also raises single-cycle strobes that tell the bit engine when SDA may move and when the slave's data should be sampled. Every interval is programmable, counted in ticks of a prescaler that divides the input clock by `div+1`. Each bus condition has its own setup or hold count. A data bit also carries a fixed overhead of 8 input clocks plus twice the filter count. This overhead covers the latency of the SCL readback through the input filter. As a result, one bit period is exactly (div+1)·(low+high+2) + 8 + 2·flt input clocks.

The block also has two identical input glitch filters, one for SCL and one for SDA as read back from the bus. A filter passes a new level only after that level has held for `flt+1` consecutive input clocks.

A command is accepted in any cycle where `cmd_rdy` and `cmd_valid` are both high. The block returns to ready in the cycle it pulses `done`, so commands can follow back to back. Register decoding and the choice between timing sets are left to the surrounding logic.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, `scl_o`, `scl_filt`, `sda_filt` and `cmd_rdy` are 1, and `sda_stb`, `smp_stb` and `done` are 0.
- R2: `cmd` encodes 0 = start, 1 = data bit, 2 = stop, 3 = repeated start. A command is taken only while `cmd_rdy` is 1. `cmd_valid` raised while a command is running has no effect on that command's timing or on what follows it.
- R3: A data bit pulses `done` exactly (div+1)·(Llo+t_high+1) + 8 + 2·flt clocks after acceptance, with Llo = max(t_low, t_hd_dat+t_su_dat)+1. This is the period formula whenever t_low ≥ t_hd_dat+t_su_dat.
- R4: During a data bit, SCL is low from acceptance until (div+1)·Llo + 8 + 2·flt clocks. It rises in the same cycle as `smp_stb` and falls again in the cycle of `done`.
- R5: In every SCL-low phase (data bit, stop, repeated start), `sda_stb` pulses (t_hd_dat+1)·(div+1) clocks after the phase begins.
- R6: When t_hd_dat+t_su_dat exceeds t_low (or t_sr_rel for a repeated start), the low phase is stretched to t_hd_dat+t_su_dat+1 ticks, so the data setup time is always met.
- R7: A start holds SCL high and pulses `sda_stb` after (t_su_sta+1)·(div+1) clocks. It pulls SCL low with `done` a further (t_hd_sta+1)·(div+1) clocks later.
- R8: A stop holds SCL low for Llo ticks and then releases it. After (t_su_sto+1)·(div+1) more clocks it pulses `sda_stb` together with `done`, and SCL stays high afterwards.
- R9: A repeated start holds SCL low for max(t_sr_rel, t_hd_dat+t_su_dat)+1 ticks, then releases it and continues with the start timing of R7.
- R10: A filtered output takes a new raw level after that level has been present for flt+1 consecutive clocks. A differing level that lasts only flt clocks never reaches the output.
- R11: While idle with no command, SCL does not change and no strobe is raised.
- R12: `sda_stb` and `smp_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div | input | 8 | Prescaler divide minus one |
| t_low | input | 8 | SCL low count |
| t_high | input | 8 | SCL high count |
| t_su_sta | input | 8 | Start setup count |
| t_hd_sta | input | 8 | Start hold count |
| t_su_sto | input | 8 | Stop setup count |
| t_su_dat | input | 8 | Data setup count |
| t_hd_dat | input | 8 | Data hold count |
| t_sr_rel | input | 8 | Repeated-start release count |
| flt | input | 3 | Glitch filter cycle count |
| cmd_valid | input | 1 | Command request |
| cmd | input | 2 | Command code |
| cmd_rdy | output | 1 | Ready for a command |
| scl_o | output | 1 | SCL level to drive (1 = released) |
| sda_stb | output | 1 | SDA may change now |
| smp_stb | output | 1 | Sample SDA now (SCL rising) |
| done | output | 1 | Command finished |
| scl_in | input | 1 | Raw SCL from the bus |
| sda_in | input | 1 | Raw SDA from the bus |
| scl_filt | output | 1 | Filtered SCL |
| sda_filt | output | 1 | Filtered SDA |

## Verification
The case that is hardest to reach from the ports is the one where data hold plus setup overruns the programmed low or release count, so the low phase is stretched. Only certain combinations of three counts reach it. The sweep crosses small low counts with setup values that both fit inside and overrun them, at several divider and filter settings. Every command type is timed in each combination against closed-form cycle counts. Requests raised in the middle of a stop command check that a busy sequencer ignores them.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

  typedef enum logic [1:0] {
    CMD_START  = 2'd0,
    CMD_BIT    = 2'd1,
    CMD_STOP   = 2'd2,
    CMD_RSTART = 2'd3
  } tg_cmd_t;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_STA_SU,
    PH_STA_HD,
    PH_BIT_LO,
    PH_BIT_OV,
    PH_BIT_HI,
    PH_SP_LO,
    PH_SP_SU,
    PH_RS_LO
  } tg_phase_t;

endpackage

// File: rtl/scl_glitch_filter.sv
module scl_glitch_filter #(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] flt,
  input  logic          raw,
  output logic          filt
);

  logic [FW-1:0] cnt_q, cnt_d;
  logic          filt_q, filt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (raw != filt_q) begin
      if (cnt_q == flt) begin
        filt_d = raw;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  assign filt = filt_q;

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [DW-1:0] div,
  output logic          tick
);

  logic [DW-1:0] pre_q, pre_d;

  assign tick = (pre_q == div);

  always_comb begin
    if (clr || tick) pre_d = '0;
    else             pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_tg_pkg::*;
#(
  parameter int CW = 8,
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd,
  input  logic [CW-1:0] t_low,
  input  logic [CW-1:0] t_high,
  input  logic [CW-1:0] t_su_sta,
  input  logic [CW-1:0] t_hd_sta,
  input  logic [CW-1:0] t_su_sto,
  input  logic [CW-1:0] t_su_dat,
  input  logic [CW-1:0] t_hd_dat,
  input  logic [CW-1:0] t_sr_rel,
  input  logic [FW-1:0] flt,
  output logic          pre_clr,
  output logic          cmd_rdy,
  output logic          scl_o,
  output logic          sda_stb,
  output logic          smp_stb,
  output logic          done
);

  localparam int LW    = CW + 1;
  localparam int OVMAX = 8 + 2 * ((1 << FW) - 1);
  localparam int OW    = $clog2(OVMAX + 1);

  tg_phase_t     state_q, state_d;
  logic [LW-1:0] cnt_q, cnt_d, plen, hs_sum, lo_len, rs_len;
  logic [OW-1:0] ocnt_q, ocnt_d, ov_len;
  logic          scl_q, scl_d, sda_q, sda_d, smp_q, smp_d, done_q, done_d;
  logic          is_ov, is_low, step, ph_end, hold_hit;

  // Low phases stretch so that hold plus setup always fits inside them
  assign hs_sum = LW'(t_hd_dat) + LW'(t_su_dat);
  assign lo_len = ((LW'(t_low) > hs_sum) ? LW'(t_low) : hs_sum) + 1'b1;
  assign rs_len = ((LW'(t_sr_rel) > hs_sum) ? LW'(t_sr_rel) : hs_sum) + 1'b1;
  assign ov_len = OW'(8) + OW'({flt, 1'b0});

  always_comb begin
    unique case (state_q)
      PH_STA_SU: plen = LW'(t_su_sta) + 1'b1;
      PH_STA_HD: plen = LW'(t_hd_sta) + 1'b1;
      PH_BIT_LO: plen = lo_len;
      PH_BIT_HI: plen = LW'(t_high) + 1'b1;
      PH_SP_LO:  plen = lo_len;
      PH_SP_SU:  plen = LW'(t_su_sto) + 1'b1;
      PH_RS_LO:  plen = rs_len;
      default:   plen = '1;
    endcase
  end

  assign is_ov    = (state_q == PH_BIT_OV);
  assign is_low   = (state_q == PH_BIT_LO) || (state_q == PH_SP_LO) || (state_q == PH_RS_LO);
  assign step     = (state_q != PH_IDLE) && !is_ov && tick;
  assign ph_end   = is_ov ? (ocnt_q == ov_len - 1'b1) : (step && (cnt_q == plen - 1'b1));
  assign hold_hit = is_low && step && (cnt_q == LW'(t_hd_dat));
  assign pre_clr  = (state_q == PH_IDLE) || is_ov || ph_end;

  always_comb begin
    state_d = state_q;
    scl_d   = scl_q;
    sda_d   = hold_hit;
    smp_d   = 1'b0;
    done_d  = 1'b0;
    cnt_d   = ph_end ? '0 : (step ? cnt_q + 1'b1 : cnt_q);
    ocnt_d  = (is_ov && !ph_end) ? ocnt_q + 1'b1 : '0;
    unique case (state_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (cmd_valid) begin
          unique case (tg_cmd_t'(cmd))
            CMD_START:  begin state_d = PH_STA_SU; scl_d = 1'b1; end
            CMD_BIT:    begin state_d = PH_BIT_LO; scl_d = 1'b0; end
            CMD_STOP:   begin state_d = PH_SP_LO;  scl_d = 1'b0; end
            CMD_RSTART: begin state_d = PH_RS_LO;  scl_d = 1'b0; end
            default:    state_d = PH_IDLE;
          endcase
        end
      end
      PH_STA_SU: if (ph_end) begin state_d = PH_STA_HD; sda_d = 1'b1; end
      PH_STA_HD: if (ph_end) begin state_d = PH_IDLE; scl_d = 1'b0; done_d = 1'b1; end
      PH_BIT_LO: if (ph_end) state_d = PH_BIT_OV;
      PH_BIT_OV: if (ph_end) begin state_d = PH_BIT_HI; scl_d = 1'b1; smp_d = 1'b1; end
      PH_BIT_HI: if (ph_end) begin state_d = PH_IDLE; scl_d = 1'b0; done_d = 1'b1; end
      PH_SP_LO:  if (ph_end) begin state_d = PH_SP_SU; scl_d = 1'b1; end
      PH_SP_SU:  if (ph_end) begin state_d = PH_IDLE; sda_d = 1'b1; done_d = 1'b1; end
      PH_RS_LO:  if (ph_end) begin state_d = PH_STA_SU; scl_d = 1'b1; end
      default:   state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      ocnt_q  <= '0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b0;
      smp_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ocnt_q  <= ocnt_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      smp_q   <= smp_d;
      done_q  <= done_d;
    end
  end

  assign cmd_rdy = (state_q == PH_IDLE);
  assign scl_o   = scl_q;
  assign sda_stb = sda_q;
  assign smp_stb = smp_q;
  assign done    = done_q;

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int CW = 8,
  parameter int DW = 8,
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] div,
  input  logic [CW-1:0] t_low,
  input  logic [CW-1:0] t_high,
  input  logic [CW-1:0] t_su_sta,
  input  logic [CW-1:0] t_hd_sta,
  input  logic [CW-1:0] t_su_sto,
  input  logic [CW-1:0] t_su_dat,
  input  logic [CW-1:0] t_hd_dat,
  input  logic [CW-1:0] t_sr_rel,
  input  logic [FW-1:0] flt,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd,
  output logic          cmd_rdy,
  output logic          scl_o,
  output logic          sda_stb,
  output logic          smp_stb,
  output logic          done,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_filt,
  output logic          sda_filt
);

  localparam int NLINES = 2;

  logic             tick, pre_clr;
  logic [NLINES-1:0] raw_bus, filt_bus;

  scl_prescaler #(.DW(DW)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (pre_clr),
    .div  (div),
    .tick (tick)
  );

  scl_phase_seq #(.CW(CW), .FW(FW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cmd_valid(cmd_valid),
    .cmd      (cmd),
    .t_low    (t_low),
    .t_high   (t_high),
    .t_su_sta (t_su_sta),
    .t_hd_sta (t_hd_sta),
    .t_su_sto (t_su_sto),
    .t_su_dat (t_su_dat),
    .t_hd_dat (t_hd_dat),
    .t_sr_rel (t_sr_rel),
    .flt      (flt),
    .pre_clr  (pre_clr),
    .cmd_rdy  (cmd_rdy),
    .scl_o    (scl_o),
    .sda_stb  (sda_stb),
    .smp_stb  (smp_stb),
    .done     (done)
  );

  assign raw_bus = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    scl_glitch_filter #(.FW(FW)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .flt  (flt),
      .raw  (raw_bus[g]),
      .filt (filt_bus[g])
    );
  end

  assign scl_filt = filt_bus[0];
  assign sda_filt = filt_bus[1];

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_rdy,
  input logic scl_o,
  input logic sda_stb,
  input logic smp_stb,
  input logic done,
  input logic scl_in,
  input logic sda_in,
  input logic scl_filt,
  input logic sda_filt
);

  AST_SMP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> (scl_o && !$past(scl_o))) else $error("smp_stb without SCL rise"); // R4

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_rdy && !$past(cmd_rdy))) else $error("done outside end of command"); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rdy && $past(cmd_rdy)) |-> ($stable(scl_o) && !sda_stb && !smp_stb)) else $error("activity while idle"); // R11

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sda_stb, smp_stb})) else $error("strobes overlap"); // R12

  AST_SCL_FILT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_filt) |-> (scl_filt == $past(scl_in))) else $error("scl filter took foreign level"); // R10

  AST_SDA_FILT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_filt) |-> (sda_filt == $past(sda_in))) else $error("sda filter took foreign level"); // R10

endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmd_rdy (cmd_rdy),
  .scl_o   (scl_o),
  .sda_stb (sda_stb),
  .smp_stb (smp_stb),
  .done    (done),
  .scl_in  (scl_in),
  .sda_in  (sda_in),
  .scl_filt(scl_filt),
  .sda_filt(sda_filt)
);

// File: tb/scl_timing_gen_test.sv
`timescale 1ns/1ps
module scl_timing_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div = '0, t_low = '0, t_high = '0, t_su_sta = '0, t_hd_sta = '0;
  logic [7:0] t_su_sto = '0, t_su_dat = '0, t_hd_dat = '0, t_sr_rel = '0;
  logic [2:0] flt = '0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd = '0;
  logic       scl_in = 1'b1, sda_in = 1'b1;
  logic       cmd_rdy, scl_o, sda_stb, smp_stb, done, scl_filt, sda_filt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  scl_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .div(div), .t_low(t_low), .t_high(t_high),
    .t_su_sta(t_su_sta), .t_hd_sta(t_hd_sta), .t_su_sto(t_su_sto),
    .t_su_dat(t_su_dat), .t_hd_dat(t_hd_dat), .t_sr_rel(t_sr_rel), .flt(flt),
    .cmd_valid(cmd_valid), .cmd(cmd), .cmd_rdy(cmd_rdy), .scl_o(scl_o),
    .sda_stb(sda_stb), .smp_stb(smp_stb), .done(done), .scl_in(scl_in),
    .sda_in(sda_in), .scl_filt(scl_filt), .sda_filt(sda_filt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Runs one command; -1 means the event must not occur.
  task automatic run_cmd(input logic [1:0] c, input string tag, input int e_sda1,
                         input int e_sda2, input int e_smp, input int e_rise,
                         input int e_done, input int e_scl_end, input bit poke);
    int k = 0, sda1 = -1, sda2 = -1, smp = -1, rise = -1, dn = -1;
    logic prev;
    @(negedge clk);
    chk({tag, " ready before"}, int'(cmd_rdy), 1);
    cmd_valid = 1'b1;
    cmd = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    prev = scl_o;
    while (k < 5000) begin
      if (sda_stb) begin
        if (sda1 < 0) sda1 = k; else if (sda2 < 0) sda2 = k;
      end
      if (smp_stb && smp < 0) smp = k;
      if (k > 0 && scl_o && !prev && rise < 0) rise = k;
      prev = scl_o;
      if (done) begin dn = k; break; end
      if (poke && k == 2) begin cmd_valid = 1'b1; cmd = 2'd0; end
      else cmd_valid = 1'b0;
      @(negedge clk);
      k++;
    end
    cmd_valid = 1'b0;
    chk({tag, " done"}, dn, e_done);
    chk({tag, " sda first"}, sda1, e_sda1);
    chk({tag, " sda second"}, sda2, e_sda2);
    chk({tag, " sample"}, smp, e_smp);
    chk({tag, " scl rise"}, rise, e_rise);
    chk({tag, " scl end"}, int'(scl_o), e_scl_end);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 scl", int'(scl_o), 1);
    chk("R1 rdy", int'(cmd_rdy), 1);
    chk("R1 strobes", int'({sda_stb, smp_stb, done}), 0);
    chk("R1 filt", int'({scl_filt, sda_filt}), 3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int d = 0; d < 3; d++)
      for (int f = 0; f < 3; f++)
        for (int tl = 2; tl <= 5; tl += 3)
          for (int th = 1; th <= 3; th += 2)
            for (int hd = 0; hd < 2; hd++)
              for (int su = 1; su <= 4; su += 3) begin
                int p, llo, lrs, a, b;
                div = 8'(d); flt = 3'(f); t_low = 8'(tl); t_high = 8'(th);
                t_hd_dat = 8'(hd); t_su_dat = 8'(su); t_sr_rel = 8'(tl);
                t_su_sta = 8'(th + 1); t_hd_sta = 8'(tl); t_su_sto = 8'(th);
                p   = d + 1;
                llo = ((tl > hd + su) ? tl : hd + su) + 1;  // R6 stretch
                lrs = llo;
                // R7 start
                a = (th + 2) * p;
                run_cmd(2'd0, "R7", a, -1, -1, -1, a + (tl + 1) * p, 0, 1'b0);
                // R3 R4 R5 data bit
                a = llo * p + 8 + 2 * f;
                run_cmd(2'd1, "R3", (hd + 1) * p, -1, a, a, a + (th + 1) * p, 0, 1'b0);
                // R9 repeated start
                a = lrs * p;
                b = a + (th + 2) * p;
                run_cmd(2'd3, "R9", (hd + 1) * p, b, -1, a, b + (tl + 1) * p, 0, 1'b0);
                // R8 stop, with an ignored request while busy (R2)
                a = llo * p;
                b = a + (th + 1) * p;
                run_cmd(2'd2, "R8", (hd + 1) * p, b, -1, a, b, 1, 1'b1);
                // R2 R11: request during stop was dropped; bus stays quiet
                for (int i = 0; i < 6; i++) begin
                  @(negedge clk);
                  chk("R11 idle scl", int'(scl_o), 1);
                  chk("R2 ignored", int'({sda_stb, smp_stb, done}), 0);
                  chk("R2 ready", int'(cmd_rdy), 1);
                end
              end

    // R10 glitch filter
    for (int f = 0; f < 8; f++) begin
      flt = 3'(f);
      @(negedge clk);
      sda_in = 1'b0;
      for (int i = 1; i <= f; i++) @(negedge clk);
      sda_in = 1'b1;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk("R10 glitch rejected", int'(sda_filt), 1);
      end
      scl_in = 1'b0;
      for (int i = 1; i <= f + 1; i++) begin
        @(negedge clk);
        chk("R10 scl filtered", int'(scl_filt), (i == f + 1) ? 0 : 1);
      end
      scl_in = 1'b1;
      repeat (f + 2) @(negedge clk);
      chk("R10 scl back", int'(scl_filt), 1);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule